// File: doc/BRIEF.md
# Transactional Line-Set Conflict Tracker

This block follows one hardware memory transaction on a single core. It records which cache lines the transaction has loaded from and stored to, and it aborts the transaction when something invalidates it. A command port opens, closes and explicitly aborts transactions, and these may nest. A local access port reports the core's own loads and stores. A snoop port carries line addresses that other cores read or write. All matching is done on whole 64-byte lines. The table has a fixed number of line slots.

When a transaction dies, the block raises a one-cycle abort pulse and returns the nesting depth to zero. It also forgets every tracked line and publishes a 32-bit cause word. That word stays readable until the next outermost begin. A successful outermost close gives a one-cycle commit pulse and also empties the table. Data buffering, coherence state and the fallback path belong to the surrounding core.

Top module: `txn_set_tracker`

## Requirements
- R1: After reset `in_txn_o` and `depth_o` are 0, `status_o` is 0, and `commit_o` and `abort_o` are low.
- R2: Commands on `cmd_op_i` are 1 = begin, 2 = commit and 3 = abort. Each begin raises `depth_o` by one. `in_txn_o` is high exactly while `depth_o` is nonzero. A commit at depth above 1 only lowers the depth and gives no pulse. A commit at depth 1 returns the depth to 0 and raises `commit_o` for one cycle.
- R3: A commit or an abort command received while `depth_o` is 0 changes nothing: no pulse, the depth stays 0 and `status_o` keeps its value.
- R4: Lines are 64 bytes, so accesses that differ only in address bits [5:0] share one table slot and use no extra capacity.
- R5: An explicit abort with code C yields `status_o` = {C, 18'b0, nested bit 5, 4'b0, bit 0 = 1}. Bit 1 is 0, bits 23:6 are 0 and bit 4 is 0.
- R6: A snoop write that hits any line the transaction has read or written aborts it with bit 2 (conflict) and bit 1 (retry may succeed) set.
- R7: A snoop read that hits a written line aborts the transaction as in R6. A snoop read that hits only read lines, or no tracked line at all, has no effect.
- R8: The table holds 8 lines. A local access to a ninth distinct line aborts with bit 3 (capacity) and bit 1 set.
- R9: Status bit 5 is set when the abort happens while the depth is greater than 1.
- R10: An abort pulses `abort_o` for exactly one cycle and sets the depth to 0. It discards all tracked lines. `status_o` holds its value until the next begin issued at depth 0, which clears it to 0.
- R11: Local accesses and snoops while the depth is 0 are ignored. An outermost commit empties the table, so lines from a finished transaction never conflict later.
- R12: When several abort causes arrive in one cycle, explicit abort wins over conflict, and conflict wins over capacity. Only the winning cause bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 1 begin, 2 commit, 3 abort |
| cmd_code_i | input | 8 | Code for an explicit abort |
| acc_valid_i | input | 1 | Local access strobe |
| acc_write_i | input | 1 | 1 store, 0 load |
| acc_addr_i | input | ADDR_W | Local byte address |
| snp_valid_i | input | 1 | Remote access strobe |
| snp_write_i | input | 1 | 1 remote write, 0 remote read |
| snp_addr_i | input | ADDR_W | Remote byte address |
| in_txn_o | output | 1 | High while inside a transaction |
| depth_o | output | DEPTH_W | Current nesting depth |
| commit_o | output | 1 | One-cycle pulse on outermost commit |
| abort_o | output | 1 | One-cycle pulse on any abort |
| status_o | output | 32 | Cause word of the last abort |

## Verification
The hardest state to reach is a full table that meets a clash of causes in the same cycle. That clash needs an explicit abort, a snoop hit and a ninth-line access all at once. The bench first fills all eight slots, touching each line at both its first and last byte to show that offsets share a slot. It then drives the three triggers together in one cycle. It repeats the fill without the command to show that a conflict outranks capacity. Nested aborts and reuse of old lines after an abort or a commit are reached through short command sequences.

// File: rtl/txn_pkg.sv
package txn_pkg;
   localparam int STATUS_W    = 32;
   localparam int CODE_W      = 8;
   localparam int BIT_EXPLICIT = 0;
   localparam int BIT_RETRY    = 1;
   localparam int BIT_CONFLICT = 2;
   localparam int BIT_CAPACITY = 3;
   localparam int BIT_NESTED   = 5;
   localparam int CODE_LSB     = 24;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_BEGIN  = 2'd1,
      CMD_COMMIT = 2'd2,
      CMD_ABORT  = 2'd3
   } txn_cmd_e;

   typedef struct packed {
      logic              explicit_ab;
      logic              conflict;
      logic              capacity;
      logic              nested;
      logic [CODE_W-1:0] code;
   } abort_cause_t;
endpackage

// File: rtl/txn_line_table.sv
module txn_line_table #(
   parameter int ENTRIES = 8,
   parameter int TAG_W   = 26
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clear_i,
   input  logic             rec_i,
   input  logic             rec_write_i,
   input  logic [TAG_W-1:0] rec_tag_i,
   input  logic [TAG_W-1:0] snp_tag_i,
   output logic             acc_hit_o,
   output logic             full_o,
   output logic             snp_any_o,
   output logic             snp_wr_o
);
   logic [ENTRIES-1:0] vld, wrb, hit_acc, hit_snp, alloc_oh;

   always_comb begin
      logic found;
      found    = 1'b0;
      alloc_oh = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!vld[i] && !found) begin
            alloc_oh[i] = 1'b1;
            found       = 1'b1;
         end
      end
   end

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
         logic             v_q, r_q, w_q;
         logic [TAG_W-1:0] t_q;
         logic             take;

         assign hit_acc[g] = v_q && (t_q == rec_tag_i);
         assign hit_snp[g] = v_q && (t_q == snp_tag_i);
         assign vld[g]     = v_q;
         assign wrb[g]     = w_q;
         assign take       = rec_i && (hit_acc[g] || (!acc_hit_o && alloc_oh[g]));

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               v_q <= 1'b0;
               r_q <= 1'b0;
               w_q <= 1'b0;
               t_q <= '0;
            end else if (clear_i) begin
               v_q <= 1'b0;
               r_q <= 1'b0;
               w_q <= 1'b0;
            end else if (take) begin
               v_q <= 1'b1;
               t_q <= rec_tag_i;
               if (rec_write_i) w_q <= 1'b1;
               else             r_q <= 1'b1;
            end
         end

         logic unused_rd_flag;
         assign unused_rd_flag = r_q;
      end
   endgenerate

   assign acc_hit_o = |hit_acc;
   assign full_o    = &vld;
   assign snp_any_o = |hit_snp;
   assign snp_wr_o  = |(hit_snp & wrb);
endmodule

// File: rtl/txn_nest_ctr.sv
module txn_nest_ctr #(
   parameter int DEPTH_W = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               inc_i,
   input  logic               dec_i,
   input  logic               flush_i,
   output logic [DEPTH_W-1:0] depth_o,
   output logic               active_o,
   output logic               outer_o,
   output logic               deep_o
);
   localparam logic [DEPTH_W-1:0] DMAX = '1;
   localparam logic [DEPTH_W-1:0] ONE  = DEPTH_W'(1);

   logic [DEPTH_W-1:0] depth_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        depth_q <= '0;
      else if (flush_i)                   depth_q <= '0;
      else if (inc_i && depth_q != DMAX)  depth_q <= depth_q + ONE;
      else if (dec_i && depth_q != '0)    depth_q <= depth_q - ONE;
   end

   assign depth_o  = depth_q;
   assign active_o = depth_q != '0;
   assign outer_o  = depth_q == ONE;
   assign deep_o   = depth_q > ONE;
endmodule

// File: rtl/txn_abort_enc.sv
module txn_abort_enc
   import txn_pkg::*;
(
   input  abort_cause_t          cause_i,
   output logic [STATUS_W-1:0]   word_o
);
   always_comb begin
      word_o                  = '0;
      word_o[BIT_EXPLICIT]    = cause_i.explicit_ab;
      word_o[BIT_RETRY]       = !cause_i.explicit_ab && (cause_i.conflict || cause_i.capacity);
      word_o[BIT_CONFLICT]    = cause_i.conflict;
      word_o[BIT_CAPACITY]    = cause_i.capacity;
      word_o[BIT_NESTED]      = cause_i.nested;
      word_o[CODE_LSB +: CODE_W] = cause_i.explicit_ab ? cause_i.code : '0;
   end
endmodule

// File: rtl/txn_set_tracker.sv
module txn_set_tracker
   import txn_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int ENTRIES    = 8,
   parameter int DEPTH_W    = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cmd_valid_i,
   input  logic [1:0]         cmd_op_i,
   input  logic [7:0]         cmd_code_i,
   input  logic               acc_valid_i,
   input  logic               acc_write_i,
   input  logic [ADDR_W-1:0]  acc_addr_i,
   input  logic               snp_valid_i,
   input  logic               snp_write_i,
   input  logic [ADDR_W-1:0]  snp_addr_i,
   output logic               in_txn_o,
   output logic [DEPTH_W-1:0] depth_o,
   output logic               commit_o,
   output logic               abort_o,
   output logic [31:0]        status_o
);
   localparam int OFFSET_W = $clog2(LINE_BYTES);
   localparam int TAG_W    = ADDR_W - OFFSET_W;

   if (LINE_BYTES < 1 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if (ENTRIES < 1) begin : g_bad_entries
      $error("ENTRIES must be at least one");
   end
   if (DEPTH_W < 2) begin : g_bad_depth
      $error("DEPTH_W must be at least two");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   logic [TAG_W-1:0] acc_tag, snp_tag;
   generate
      if (OFFSET_W == 0) begin : g_tag_flat
         assign acc_tag = acc_addr_i;
         assign snp_tag = snp_addr_i;
      end else begin : g_tag_line
         assign acc_tag = acc_addr_i[ADDR_W-1:OFFSET_W];
         assign snp_tag = snp_addr_i[ADDR_W-1:OFFSET_W];
         logic offs_unused;
         assign offs_unused = ^{acc_addr_i[OFFSET_W-1:0], snp_addr_i[OFFSET_W-1:0]};
      end
   endgenerate

   logic active, outer, deep;
   logic acc_hit, full, snp_any, snp_wr;
   logic is_begin, is_commit, is_abort;
   logic exp_ab, conf, cap, abort_now, commit_now, rec;
   abort_cause_t cause;
   logic [STATUS_W-1:0] word;

   assign is_begin  = cmd_valid_i && (cmd_op_i == CMD_BEGIN);
   assign is_commit = cmd_valid_i && (cmd_op_i == CMD_COMMIT);
   assign is_abort  = cmd_valid_i && (cmd_op_i == CMD_ABORT);

   assign exp_ab     = active && is_abort;
   assign conf       = active && snp_valid_i && (snp_wr || (snp_write_i && snp_any));
   assign cap        = active && acc_valid_i && !acc_hit && full;
   assign abort_now  = exp_ab || conf || cap;
   assign commit_now = active && is_commit && outer && !abort_now;
   assign rec        = active && acc_valid_i && !abort_now;

   txn_nest_ctr #(.DEPTH_W(DEPTH_W)) u_nest (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (is_begin),
      .dec_i    (is_commit),
      .flush_i  (abort_now),
      .depth_o  (depth_o),
      .active_o (active),
      .outer_o  (outer),
      .deep_o   (deep)
   );

   txn_line_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_table (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clear_i     (abort_now || commit_now),
      .rec_i       (rec),
      .rec_write_i (acc_write_i),
      .rec_tag_i   (acc_tag),
      .snp_tag_i   (snp_tag),
      .acc_hit_o   (acc_hit),
      .full_o      (full),
      .snp_any_o   (snp_any),
      .snp_wr_o    (snp_wr)
   );

   always_comb begin
      cause.explicit_ab = exp_ab;
      cause.conflict    = !exp_ab && conf;
      cause.capacity    = !exp_ab && !conf && cap;
      cause.nested      = deep;
      cause.code        = cmd_code_i;
   end

   txn_abort_enc u_enc (
      .cause_i (cause),
      .word_o  (word)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         status_o <= '0;
         abort_o  <= 1'b0;
         commit_o <= 1'b0;
      end else begin
         abort_o  <= abort_now;
         commit_o <= commit_now;
         if (abort_now)                  status_o <= word;
         else if (is_begin && !active)   status_o <= '0;
      end
   end

   assign in_txn_o = active;
endmodule

// File: rtl/txn_set_tracker_chk.sv
module txn_set_tracker_chk (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        cmd_valid_i,
   input logic [1:0]  cmd_op_i,
   input logic        in_txn_o,
   input logic        commit_o,
   input logic        abort_o,
   input logic [31:0] status_o
);
   assert_no_retry_on_explicit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[0] |-> !status_o[1]);

   assert_reserved_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[23:6] == 18'd0) && !status_o[4]);

   assert_code_only_explicit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[31:24] != 8'd0) |-> status_o[0]);

   assert_abort_leaves_txn_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o |-> !in_txn_o);

   assert_abort_single_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o |=> !abort_o);

   assert_status_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!in_txn_o && !(cmd_valid_i && cmd_op_i == 2'd1)) |=> $stable(status_o));

   assert_single_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({status_o[0], status_o[2], status_o[3]}));

   assert_commit_abort_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(commit_o && abort_o));
endmodule

bind txn_set_tracker txn_set_tracker_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .cmd_valid_i (cmd_valid_i),
   .cmd_op_i    (cmd_op_i),
   .in_txn_o    (in_txn_o),
   .commit_o    (commit_o),
   .abort_o     (abort_o),
   .status_o    (status_o)
);

// File: tb/txn_set_tracker_test.sv
`timescale 1ns/1ps
module txn_set_tracker_test;
   localparam int AW = 32;
   localparam int DW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_v = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic [7:0]    cmd_code = 8'd0;
   logic          acc_v = 1'b0;
   logic          acc_w = 1'b0;
   logic [AW-1:0] acc_a = '0;
   logic          snp_v = 1'b0;
   logic          snp_w = 1'b0;
   logic [AW-1:0] snp_a = '0;
   logic          in_txn;
   logic [DW-1:0] depth;
   logic          commit_p;
   logic          abort_p;
   logic [31:0]   status;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   txn_set_tracker #(.ADDR_W(AW), .LINE_BYTES(64), .ENTRIES(8), .DEPTH_W(DW)) uut (
      .clk_i(clk), .rst_ni(rst_n),
      .cmd_valid_i(cmd_v), .cmd_op_i(cmd_op), .cmd_code_i(cmd_code),
      .acc_valid_i(acc_v), .acc_write_i(acc_w), .acc_addr_i(acc_a),
      .snp_valid_i(snp_v), .snp_write_i(snp_w), .snp_addr_i(snp_a),
      .in_txn_o(in_txn), .depth_o(depth), .commit_o(commit_p),
      .abort_o(abort_p), .status_o(status)
   );

   function automatic logic [31:0] st(bit ex, bit cf, bit cp, bit nest, logic [7:0] code);
      logic [31:0] w;
      w = '0;
      w[0] = ex; w[1] = !ex && (cf || cp); w[2] = cf; w[3] = cp; w[5] = nest;
      if (ex) w[31:24] = code;
      return w;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one cycle at a negedge; results are visible at the following negedge
   task automatic cycle(bit cv, logic [1:0] op, logic [7:0] code,
                        bit av, bit aw, logic [AW-1:0] aa,
                        bit sv, bit sw, logic [AW-1:0] sa);
      cmd_v = cv; cmd_op = op; cmd_code = code;
      acc_v = av; acc_w = aw; acc_a = aa;
      snp_v = sv; snp_w = sw; snp_a = sa;
      @(negedge clk);
      cmd_v = 0; acc_v = 0; snp_v = 0;
   endtask

   task automatic cmd(logic [1:0] op, logic [7:0] code = 8'd0);
      cycle(1, op, code, 0, 0, '0, 0, 0, '0);
   endtask
   task automatic acc(bit w, logic [AW-1:0] a);
      cycle(0, 2'd0, 8'd0, 1, w, a, 0, 0, '0);
   endtask
   task automatic snp(bit w, logic [AW-1:0] a);
      cycle(0, 2'd0, 8'd0, 0, 0, '0, 1, w, a);
   endtask
   task automatic idle();
      @(negedge clk);
   endtask

   task automatic fill8(logic [AW-1:0] base);
      for (int i = 0; i < 8; i++) begin
         acc(i[0], base + AW'(i * 64));
         acc(!i[0], base + AW'(i * 64 + 63));
      end
   endtask

   task automatic t_reset();
      check("R1 reset in_txn/depth/pulses", {26'd0, in_txn, depth, commit_p, abort_p}, 32'd0);
      check("R1 reset status", status, 32'd0);
   endtask

   task automatic t_nesting();
      cmd(2'd1);
      check("R2 first begin", {in_txn, depth}, {1'b1, 4'd1});
      cmd(2'd1);
      check("R2 second begin", {in_txn, depth}, {1'b1, 4'd2});
      cmd(2'd2);
      check("R2 inner commit", {in_txn, depth, commit_p}, {1'b1, 4'd1, 1'b0});
      cmd(2'd2);
      check("R2 outer commit", {in_txn, depth, commit_p}, {1'b0, 4'd0, 1'b1});
      idle();
      check("R2 commit pulse one cycle", {31'd0, commit_p}, 32'd0);
   endtask

   task automatic t_explicit();
      cmd(2'd1);
      acc(1, 32'h0000_0800);
      cmd(2'd3, 8'hA5);
      check("R5 explicit status", status, st(1, 0, 0, 0, 8'hA5));
      check("R10 abort pulse and depth", {abort_p, in_txn, depth}, {1'b1, 1'b0, 4'd0});
      idle();
      check("R10 abort pulse ends", {31'd0, abort_p}, 32'd0);
      cmd(2'd2);
      check("R3 commit outside", {commit_p, abort_p, depth}, 6'd0);
      cmd(2'd3, 8'h77);
      check("R3 abort outside keeps status", status, st(1, 0, 0, 0, 8'hA5));
      check("R3 abort outside no pulse", {abort_p, depth}, 5'd0);
      cmd(2'd1);
      check("R10 begin clears status", status, 32'd0);
      cmd(2'd2);
   endtask

   task automatic t_nested_abort();
      cmd(2'd1);
      cmd(2'd1);
      cmd(2'd1);
      cmd(2'd3, 8'h3C);
      check("R9 nested explicit status", status, st(1, 0, 0, 1, 8'h3C));
      check("R9 depth back to zero", {abort_p, depth}, {1'b1, 4'd0});
      cmd(2'd1);
      cmd(2'd1);
      acc(0, 32'h0000_9000);
      snp(1, 32'h0000_9010);
      check("R9 nested conflict status", status, st(0, 1, 0, 1, 8'h00));
   endtask

   task automatic t_conflicts();
      cmd(2'd1);
      acc(0, 32'h0000_1000);
      snp(1, 32'h0000_1020);
      check("R6 remote write on read line", status, st(0, 1, 0, 0, 8'h00));
      check("R6 abort pulse", {abort_p, in_txn}, 2'b10);
      cmd(2'd1);
      acc(1, 32'h0000_2040);
      snp(1, 32'h0000_207F);
      check("R6 remote write on written line", status, st(0, 1, 0, 0, 8'h00));
      cmd(2'd1);
      acc(0, 32'h0000_3000);
      snp(0, 32'h0000_3010);
      check("R7 remote read on read line ignored", {abort_p, in_txn}, 2'b01);
      snp(0, 32'h0000_5000);
      check("R7 remote read elsewhere ignored", {abort_p, in_txn}, 2'b01);
      acc(1, 32'h0000_3100);
      snp(0, 32'h0000_313F);
      check("R7 remote read on written line", status, st(0, 1, 0, 0, 8'h00));
   endtask

   task automatic t_capacity();
      cmd(2'd1);
      fill8(32'h0000_4000);
      check("R4 sixteen accesses in eight lines", {abort_p, in_txn}, 2'b01);
      acc(0, 32'h0000_4085);
      check("R4 offset inside held line", {abort_p, in_txn}, 2'b01);
      acc(0, 32'h0000_4200);
      check("R8 ninth line overflow", status, st(0, 0, 1, 0, 8'h00));
      check("R8 overflow pulse", {abort_p, in_txn}, 2'b10);
   endtask

   task automatic t_clearing();
      cmd(2'd1);
      snp(1, 32'h0000_4200);
      snp(1, 32'h0000_1000);
      check("R10 aborted lines discarded", {abort_p, in_txn}, 2'b01);
      acc(1, 32'h0000_6000);
      cmd(2'd2);
      check("R11 commit pulse", {31'd0, commit_p}, 32'd1);
      acc(1, 32'h0000_7000);
      snp(1, 32'h0000_6000);
      cmd(2'd1);
      snp(1, 32'h0000_6000);
      snp(1, 32'h0000_7000);
      check("R11 committed and idle lines gone", {abort_p, in_txn}, 2'b01);
      cmd(2'd2);
   endtask

   task automatic t_priority();
      cmd(2'd1);
      fill8(32'h0001_0000);
      cycle(1, 2'd3, 8'h11, 1, 0, 32'h0001_0400, 1, 1, 32'h0001_0000);
      check("R12 explicit beats conflict and capacity", status, st(1, 0, 0, 0, 8'h11));
      cmd(2'd1);
      fill8(32'h0002_0000);
      cycle(0, 2'd0, 8'h00, 1, 0, 32'h0002_0400, 1, 1, 32'h0002_0040);
      check("R12 conflict beats capacity", status, st(0, 1, 0, 0, 8'h00));
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      idle();
      t_reset();
      t_nesting();
      t_explicit();
      t_nested_abort();
      t_conflicts();
      t_capacity();
      t_clearing();
      t_priority();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end
endmodule